// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out the three counted-loop primitives of a small processor core: count down and branch, count up and branch, and test and branch. Each operation is described by a control byte and an 8-bit displacement byte. The control byte holds the operation kind, the branch condition, the ninth (sign) bit of the displacement, and the index of the register to work on. The unit drives the register index to an external register file and receives that register's value on the same cycle. One clock edge later it presents the modified value with a write enable, a branch-taken flag, the branch target and the resulting next PC.

The caller supplies the PC value that follows the displacement byte. The register file, the fetch logic and the PC register stay outside the unit. The modified value is written back on every legal operation, so a loop counter advances even when the loop exits. The one unused operation code is flagged as illegal and has no side effect.

Top module: `loop_branch_unit`

## Requirements
- R1: Control bits [7:6] select the operation: 00 subtracts one from the register value, 01 leaves it unchanged, and 10 adds one. The result appears on `wr_data`.
- R2: Register indices 0, 1 and 2 are byte-wide. For these, the arithmetic and the zero test use only bits [7:0] of `src_value`, wrapping modulo 256, and `wr_data[15:8]` is 0. Indices 3 to 7 are 16-bit and wrap modulo 65536.
- R3: With control bit [5] = 1 the branch is taken when the modified value is non-zero. With bit [5] = 0 it is taken when the modified value is zero.
- R4: `target` equals `pc_next` plus a 9-bit signed offset, wrapping modulo 65536. Control bit [4] is the sign and `disp_byte` supplies the low eight bits.
- R5: `next_pc` equals `target` when the branch is taken and `pc_next` otherwise.
- R6: `rd_sel` follows control bits [2:0] combinationally. Every legal operation asserts `wr_en` with `wr_sel` equal to those bits, whether or not the branch is taken.
- R7: Control bits [7:6] = 11 set `illegal_op`, with `wr_en` and `taken` low and `next_pc` equal to `pc_next`.
- R8: Results appear one clock after `op_valid` with `res_valid` high. A cycle without `op_valid` yields `res_valid`, `wr_en`, `taken` and `illegal_op` all low.
- R9: While `rst_n` is low, every registered output is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Control, displacement, PC and source value are valid this cycle |
| ctrl_byte | input | 8 | Operation, condition, displacement sign, register index |
| disp_byte | input | 8 | Low eight bits of the displacement |
| pc_next | input | 16 | PC following the displacement byte |
| src_value | input | 16 | Value read from the register at `rd_sel` |
| rd_sel | output | 3 | Register index driven to the register file |
| res_valid | output | 1 | Registered result is valid |
| wr_en | output | 1 | Write `wr_data` into register `wr_sel` |
| wr_sel | output | 3 | Register index for the write |
| wr_data | output | 16 | Modified register value |
| taken | output | 1 | Branch taken |
| target | output | 16 | Branch target |
| next_pc | output | 16 | PC to continue at |
| illegal_op | output | 1 | Operation code 11 was seen |

## Verification
The hardest cases are those where a byte-wide register reaches zero while the read bus carries non-zero upper bits. If the unit ignored the width, the zero test and the written value would both differ from the correct result. The stimulus drives values such as 0xFF01 for register 1 and 0xAB00 for register 2. It also wraps 0xFF and 0xFFFF upward, and places `pc_next` near 0x0000 and 0xFFFF so that a negative or positive nine-bit offset wraps the target.

// File: rtl/lcb_pkg.sv
package lcb_pkg;

  typedef enum logic [1:0] {
    LC_DEC = 2'b00,
    LC_TST = 2'b01,
    LC_INC = 2'b10,
    LC_BAD = 2'b11
  } lc_op_e;

endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic [CTRL_W-1:0] ctrl,
  output lc_op_e            op,
  output logic              cond_nz,
  output logic              disp_neg,
  output logic [SEL_W-1:0]  sel,
  output logic              illegal
);

  always_comb begin
    op       = lc_op_e'(ctrl[7:6]);
    cond_nz  = ctrl[5];
    disp_neg = ctrl[4];
    sel      = ctrl[SEL_W-1:0];
    illegal  = (op == LC_BAD);
  end

endmodule

// File: rtl/lcb_count.sv
module lcb_count
  import lcb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int NARROW_W    = 8,
  parameter int SEL_W       = 3,
  parameter int NARROW_REGS = 3
) (
  input  lc_op_e            op,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] new_value,
  output logic              is_zero,
  output logic              narrow
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  function automatic logic [DATA_W-1:0] step_value(
    input lc_op_e op_i, input logic [DATA_W-1:0] v, input logic nar);
    logic [DATA_W-1:0] r;
    case (op_i)
      LC_DEC:  r = v - ONE;
      LC_INC:  r = v + ONE;
      default: r = v;
    endcase
    return nar ? (r & NARROW_MASK) : r;
  endfunction

  always_comb begin
    narrow    = (int'(sel) < NARROW_REGS);
    new_value = step_value(op, value, narrow);
    is_zero   = (new_value == '0);
  end

endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int DATA_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [DATA_W-1:0] pc_after,
  input  logic [DISP_W-1:0] disp,
  input  logic              neg,
  output logic [DATA_W-1:0] target
);

  function automatic logic [DATA_W-1:0] offset_of(
    input logic [DISP_W-1:0] d, input logic s);
    return {{(DATA_W-DISP_W){s}}, d};
  endfunction

  always_comb target = pc_after + offset_of(disp, neg);

endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import lcb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DISP_W      = 8,
  parameter int CTRL_W      = 8,
  parameter int SEL_W       = 3,
  parameter int NARROW_W    = 8,
  parameter int NARROW_REGS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [CTRL_W-1:0] ctrl_byte,
  input  logic [DISP_W-1:0] disp_byte,
  input  logic [DATA_W-1:0] pc_next,
  input  logic [DATA_W-1:0] src_value,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              res_valid,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data,
  output logic              taken,
  output logic [DATA_W-1:0] target,
  output logic [DATA_W-1:0] next_pc,
  output logic              illegal_op
);

  lc_op_e            dec_op;
  logic              dec_cond_nz;
  logic              dec_neg;
  logic [SEL_W-1:0]  dec_sel;
  logic              dec_illegal;
  logic [DATA_W-1:0] cnt_value;
  logic              cnt_zero;
  logic              cnt_narrow;
  logic [DATA_W-1:0] tgt_value;
  logic              branch_hit;
  logic [DATA_W-1:0] pc_choice;

  lcb_decode #(.CTRL_W(CTRL_W), .SEL_W(SEL_W)) u_decode (
    .ctrl     (ctrl_byte),
    .op       (dec_op),
    .cond_nz  (dec_cond_nz),
    .disp_neg (dec_neg),
    .sel      (dec_sel),
    .illegal  (dec_illegal)
  );

  lcb_count #(
    .DATA_W(DATA_W), .NARROW_W(NARROW_W),
    .SEL_W(SEL_W), .NARROW_REGS(NARROW_REGS)
  ) u_count (
    .op        (dec_op),
    .sel       (dec_sel),
    .value     (src_value),
    .new_value (cnt_value),
    .is_zero   (cnt_zero),
    .narrow    (cnt_narrow)
  );

  lcb_target #(.DATA_W(DATA_W), .DISP_W(DISP_W)) u_target (
    .pc_after (pc_next),
    .disp     (disp_byte),
    .neg      (dec_neg),
    .target   (tgt_value)
  );

  assign rd_sel     = dec_sel;
  assign branch_hit = !dec_illegal && (dec_cond_nz ? !cnt_zero : cnt_zero);
  assign pc_choice  = branch_hit ? tgt_value : pc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      wr_en      <= 1'b0;
      wr_sel     <= '0;
      wr_data    <= '0;
      taken      <= 1'b0;
      target     <= '0;
      next_pc    <= '0;
      illegal_op <= 1'b0;
    end else begin
      res_valid  <= op_valid;
      wr_en      <= op_valid && !dec_illegal;
      taken      <= op_valid && branch_hit;
      illegal_op <= op_valid && dec_illegal;
      if (op_valid) begin
        wr_sel  <= dec_sel;
        wr_data <= cnt_value;
        target  <= tgt_value;
        next_pc <= pc_choice;
      end
    end
  end

  // R8: no activity without a valid result
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!wr_en && !taken && !illegal_op));

  // R7: the unused code never writes or branches
  assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (!wr_en && !taken));

  // R6: every legal result writes back
  assert_legal_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !illegal_op) |-> wr_en);

  // R2: byte-wide registers never carry upper bits
  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (int'(wr_sel) < NARROW_REGS)) |-> (wr_data[DATA_W-1:NARROW_W] == '0));

  // R5: redirect matches the taken flag
  assert_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (taken ? (next_pc == target) : (next_pc == $past(pc_next))));

  // R1: a test on a wide register returns the value read
  assert_test_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ctrl_byte[7:6] == 2'b01 && int'(ctrl_byte[SEL_W-1:0]) >= NARROW_REGS)
      |=> (wr_data == $past(src_value)));

  // R3: taken follows the condition bit applied to the written value
  assert_condition_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ctrl_byte[7:6] != 2'b11)
      |=> (taken == ($past(ctrl_byte[5]) ? (wr_data != '0) : (wr_data == '0))));

endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  ctrl_byte = '0;
  logic [7:0]  disp_byte = '0;
  logic [15:0] pc_next = '0;
  logic [15:0] src_value = '0;
  logic [2:0]  rd_sel;
  logic        res_valid, wr_en, taken, illegal_op;
  logic [2:0]  wr_sel;
  logic [15:0] wr_data, target, next_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  loop_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .ctrl_byte(ctrl_byte),
    .disp_byte(disp_byte), .pc_next(pc_next), .src_value(src_value),
    .rd_sel(rd_sel), .res_valid(res_valid), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .taken(taken), .target(target), .next_pc(next_pc),
    .illegal_op(illegal_op)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one operation and checks the registered outcome one clock later
  task automatic do_op(input logic [7:0] c, input logic [7:0] d,
                       input logic [15:0] pc, input logic [15:0] src);
    logic [1:0]  op;
    logic [2:0]  sel;
    bit          byte_reg, ill, tk;
    logic [15:0] base, nv, off, tgt, npc;
    op       = c[7:6];
    sel      = c[2:0];
    byte_reg = (sel <= 3'd2);
    base     = byte_reg ? {8'h00, src[7:0]} : src;
    nv       = (op == 2'b00) ? base - 16'd1 : (op == 2'b10) ? base + 16'd1 : base;
    if (byte_reg) nv[15:8] = 8'h00;
    ill = (op == 2'b11);
    off = c[4] ? {8'hFF, d} : {8'h00, d};
    tgt = pc + off;
    tk  = !ill && (c[5] ? (nv != 16'd0) : (nv == 16'd0));
    npc = tk ? tgt : pc;

    @(negedge clk);
    op_valid = 1'b1; ctrl_byte = c; disp_byte = d; pc_next = pc; src_value = src;
    #1;
    chk(rd_sel == sel, "R6 rd_sel", 32'(rd_sel), 32'(sel));
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    chk(res_valid == 1'b1, "R8 res_valid", 32'(res_valid), 32'd1);
    chk(illegal_op == ill, "R7 illegal_op", 32'(illegal_op), 32'(ill));
    chk(wr_en == !ill, "R6 wr_en", 32'(wr_en), 32'(!ill));
    if (!ill) begin
      chk(wr_sel == sel, "R6 wr_sel", 32'(wr_sel), 32'(sel));
      chk(wr_data == nv, "R1/R2 wr_data", 32'(wr_data), 32'(nv));
    end
    chk(taken == tk, "R3 taken", 32'(taken), 32'(tk));
    chk(target == tgt, "R4 target", 32'(target), 32'(tgt));
    chk(next_pc == npc, "R5 next_pc", 32'(next_pc), 32'(npc));
  endtask

  task automatic t_reset;  // R9
    chk(res_valid == 0 && wr_en == 0 && taken == 0 && illegal_op == 0,
        "R9 flags", {28'd0, res_valid, wr_en, taken, illegal_op}, 32'd0);
    chk(wr_data == 0 && target == 0 && next_pc == 0 && wr_sel == 0,
        "R9 data", {wr_data, next_pc}, 32'd0);
  endtask

  task automatic t_decrement;  // R1 R3 R6: dec on X, branch on zero and non-zero
    do_op(8'b00_1_0_0_101, 8'h10, 16'h1000, 16'h0005);  // nz, taken
    do_op(8'b00_0_0_0_101, 8'h10, 16'h1000, 16'h0005);  // z, not taken, still writes
    do_op(8'b00_0_0_0_110, 8'h20, 16'h2000, 16'h0001);  // Y reaches zero, taken
    do_op(8'b00_1_0_0_111, 8'h04, 16'h3000, 16'h0000);  // SP wraps to FFFF
  endtask

  task automatic t_increment;  // R1 R2
    do_op(8'b10_0_0_0_100, 8'h08, 16'h4000, 16'hFFFF);  // D wraps to 0, taken
    do_op(8'b10_1_0_0_000, 8'h08, 16'h4000, 16'h00FF);  // A wraps to 0, nz not taken
    do_op(8'b10_1_0_0_011, 8'h08, 16'h4000, 16'h00FF);  // tmp is wide: 0x0100
  endtask

  task automatic t_test;  // R1: value unchanged
    do_op(8'b01_0_0_0_101, 8'h30, 16'h5000, 16'h0000);
    do_op(8'b01_1_0_0_110, 8'h30, 16'h5000, 16'hA5A5);
    do_op(8'b01_0_0_0_010, 8'h30, 16'h5000, 16'hAB00);  // R2 CCR low byte zero
  endtask

  task automatic t_narrow;  // R2: upper bits on the bus are ignored
    do_op(8'b00_0_0_0_001, 8'h02, 16'h6000, 16'hFF01);  // B to zero, taken
    do_op(8'b00_1_0_0_001, 8'h02, 16'h6000, 16'hFF00);  // B 00 -> FF
    do_op(8'b10_0_0_0_000, 8'h02, 16'h6000, 16'h12FF);  // A FF -> 00
  endtask

  task automatic t_displacement;  // R4 R5 wrap both ways
    do_op(8'b01_1_1_0_101, 8'h80, 16'h0010, 16'h0001);  // -128 below zero
    do_op(8'b01_1_1_0_101, 8'h00, 16'h0100, 16'h0001);  // -256
    do_op(8'b01_1_0_0_101, 8'hFF, 16'hFFF0, 16'h0001);  // +255 wraps
    do_op(8'b01_1_1_0_101, 8'hFF, 16'h8000, 16'h0001);  // -1
  endtask

  task automatic t_illegal;  // R7
    do_op(8'b11_1_0_0_101, 8'h10, 16'h7000, 16'h0005);
    do_op(8'b11_0_1_0_000, 8'h10, 16'h7000, 16'h0000);
  endtask

  task automatic t_idle;  // R8
    @(negedge clk);
    op_valid = 1'b0; ctrl_byte = 8'b00_0_0_0_101; src_value = 16'h0001;
    @(posedge clk);
    @(negedge clk);
    chk(!res_valid && !wr_en && !taken && !illegal_op, "R8 idle",
        {28'd0, res_valid, wr_en, taken, illegal_op}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_decrement();
    t_increment();
    t_test();
    t_narrow();
    t_displacement();
    t_illegal();
    t_idle();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule